// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (64 x 16)

This block is a synthesizable model of a small serial EEPROM that holds 64 words of 16 bits. A host drives three lines: a chip select, a serial clock and a serial data input. It reads one serial data output. All of these lines are sampled in the block's own system clock domain. Edges of the serial clock and of chip select are found by comparing each line with its value one system clock earlier.

A transaction starts with chip select high and a start bit. An 8-bit field follows, carrying a 2-bit command and a 6-bit word address. The command either moves data bits or acts at once on the internal word array. A write-protect latch gates every change to the array. A read keeps streaming words with a wrapping address for as long as chip select stays high. Every other command ends in a parked state, and only a falling edge of chip select leaves it.

Top module: `uwire_eeprom`

## Requirements
- R1: The serial data input is taken only at a rising edge of the serial clock seen while chip select is high. Clock edges seen while chip select is low have no effect.
- R2: In the wait-for-start state, rising clock edges with the data input at 0 are ignored. The first rising edge with the data input at 1 starts a command.
- R3: After the start bit, 8 bits are shifted in MSB first. Bits 7:6 are the command and bits 5:0 are the word address.
- R4: Command 01 is a word write. 16 data bits follow, MSB first. When the 16th bit arrives and the write-protect latch is open, the addressed word takes the data.
- R5: Command 10 is a read. On the edge that completes the 8-bit field, the data output goes to 0 as a dummy bit. Each following rising edge then presents the next bit of the addressed word, MSB first.
- R6: After the 16th bit of a word has been read, the read address advances by one and wraps from 63 to 0. The next word follows without a new command.
- R7: Command 11 is an erase. When the latch is open, the addressed word becomes 0xFFFF.
- R8: With command 00, bits 5:4 select the action. 01 is write-all: 16 data bits follow and go to every word. 10 is erase-all: every word becomes 0xFFFF. 00 and 11 load the write-protect latch from bit 4 (1 opens it, 0 closes it). The latch changes only at the end of such a command.
- R9: After an erase, an erase-all, a latch command or a completed write, the block ignores the serial clock until chip select falls.
- R10: A falling edge of chip select returns the block to the wait-for-start state, and the data output is 1 from the next system clock on.
- R11: After reset the latch is closed, the data output is 1, the state is wait-for-start, and word i holds INIT_WORD XOR i.
- R12: A write, write-all, erase or erase-all issued while the latch is closed leaves every word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled |
| din | input | 1 | Serial data input |
| dout | output | 1 | Serial data output |

## Verification
Some rules are checked by the assertions on every cycle:
- the data output moves only after a qualified serial clock edge or a chip-select fall;
- a chip-select fall forces the idle state and a high output;
- idle rejects zero bits;
- the parked state holds;
- no array write happens with the latch closed;
- the latch changes only from opcode collection.

Other behaviour can only be shown by the bench's scenarios:
- the values that come back from the array;
- MSB-first ordering of address and data;
- the dummy bit;
- wrapping from word 63 to word 0;
- the broadcast effect of write-all and erase-all.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int          WORDS     = 64,
  parameter int          DW        = 16,
  parameter logic [15:0] INIT_WORD = 16'h5A00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic din,
  output logic dout
);
  localparam int AW  = $clog2(WORDS);
  localparam int OPW = AW + 2;
  localparam int CW  = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_WR, S_RD, S_PARK} st_t;

  st_t           st;
  logic          cs_q, sclk_q, we;
  logic [CW-1:0] cnt;
  logic [OPW-1:0] op;
  logic [DW-1:0] sh;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] mem [WORDS];

  logic           rise, cs_fall, last_op, last_dat, wr_one, wr_all;
  logic [OPW-1:0] op_full;
  logic [AW-1:0]  wr_addr, nxt_addr;
  logic [DW-1:0]  wr_data;

  assign rise     = cs && sclk && !sclk_q;
  assign cs_fall  = cs_q && !cs;
  assign op_full  = {op[OPW-2:0], din};
  assign last_op  = rise && st == S_OPC && cnt == CW'(OPW-1);
  assign last_dat = rise && st == S_WR && cnt == CW'(DW-1);
  assign nxt_addr = rd_addr + 1'b1;

  assign wr_one = we && ((last_dat && op[OPW-1 -: 2] == 2'b01) ||
                         (last_op && op_full[OPW-1 -: 2] == 2'b11));
  assign wr_all = we && ((last_dat && op[OPW-1 -: 2] == 2'b00) ||
                         (last_op && op_full[OPW-1 -: 2] == 2'b00 &&
                          op_full[AW-1 -: 2] == 2'b10));
  assign wr_addr = (st == S_WR) ? op[AW-1:0] : op_full[AW-1:0];
  assign wr_data = (st == S_WR) ? {sh[DW-2:0], din} : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      dout    <= 1'b1;
      we      <= 1'b0;
      cnt     <= '0;
      op      <= '0;
      sh      <= '0;
      rd_addr <= '0;
    end else begin
      cs_q   <= cs;
      sclk_q <= sclk;
      if (cs_fall) begin
        st   <= S_IDLE;
        dout <= 1'b1;
      end else if (rise) begin
        case (st)
          S_IDLE: if (din) begin
            st  <= S_OPC;
            op  <= '0;
            cnt <= '0;
            sh  <= '0;
          end
          S_OPC: begin
            op  <= op_full;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(OPW-1)) begin
              cnt <= '0;
              case (op_full[OPW-1 -: 2])
                2'b01: st <= S_WR;
                2'b10: begin
                  st      <= S_RD;
                  sh      <= mem[op_full[AW-1:0]];
                  rd_addr <= op_full[AW-1:0];
                  dout    <= 1'b0;
                end
                2'b11: st <= S_PARK;
                default: begin
                  case (op_full[AW-1 -: 2])
                    2'b01:   st <= S_WR;
                    2'b10:   st <= S_PARK;
                    default: begin
                      we <= op_full[AW-2];
                      st <= S_PARK;
                    end
                  endcase
                end
              endcase
            end
          end
          S_WR: begin
            sh  <= {sh[DW-2:0], din};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW-1)) st <= S_PARK;
          end
          S_RD: begin
            dout <= sh[DW-1];
            sh   <= {sh[DW-2:0], 1'b0};
            cnt  <= cnt + 1'b1;
            if (cnt == CW'(DW-1)) begin
              cnt     <= '0;
              rd_addr <= nxt_addr;
              sh      <= mem[nxt_addr];
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= INIT_WORD[DW-1:0] ^ DW'(i);
    end else if (wr_one) begin
      mem[wr_addr] <= wr_data;
    end else if (wr_all) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= wr_data;
    end
  end
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       sclk,
  input logic       din,
  input logic       dout,
  input logic [2:0] st,
  input logic       we,
  input logic       wr_one,
  input logic       wr_all
);
  logic sclk_p, cs_p;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      cs_p   <= 1'b0;
    end else begin
      sclk_p <= sclk;
      cs_p   <= cs;
    end
  end

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs && sclk && !sclk_p) && !(cs_p && !cs)) |=> $stable(dout)); // R1
  AST_CSFALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_p && !cs) |=> (dout && st == 3'd0)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && cs && sclk && !sclk_p && !din) |=> st == 3'd0); // R2
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && cs) |=> st == 3'd4); // R9
  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one || wr_all) |-> we); // R12
  AST_LATCH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(we) |-> $past(st) == 3'd1); // R8
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din), .dout(dout),
  .st(st), .we(we), .wr_one(wr_one), .wr_all(wr_all)
);

// File: tb/sim_uwire_eeprom.sv
`timescale 1ns/1ps
module sim_uwire_eeprom;
  localparam logic [15:0] INIT = 16'h5A00;
  logic clk = 0, rst_n = 0, cs = 0, sclk = 0, din = 0;
  logic dout;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] model [64];

  uwire_eeprom #(.INIT_WORD(INIT)) u0 (.clk(clk), .rst_n(rst_n), .cs(cs),
    .sclk(sclk), .din(din), .dout(dout));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic o);
    din = b;
    repeat (2) @(negedge clk);
    sclk = 1;
    repeat (2) @(negedge clk);
    o = dout;
    sclk = 0;
    @(negedge clk);
  endtask

  task automatic deselect();
    cs = 0; sclk = 0; din = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic command(input logic [7:0] f, output logic o);
    logic x;
    cs = 1;
    @(negedge clk);
    pulse(1'b1, x);
    for (int i = 7; i >= 0; i--) pulse(f[i], o);
  endtask

  task automatic send_word(input logic [15:0] w);
    logic x;
    for (int i = 15; i >= 0; i--) pulse(w[i], x);
  endtask

  task automatic get_word(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) pulse(1'b0, w[i]);
  endtask

  task automatic read_chk(input string tag, input int a, input int n);
    logic o; logic [15:0] w;
    command({2'b10, 6'(a)}, o);
    check({tag, " dummy R5"}, {15'd0, o}, 16'd0);
    for (int k = 0; k < n; k++) begin
      get_word(w);
      check(tag, w, model[(a + k) % 64]);
    end
    deselect();
  endtask

  task automatic latch(input logic en);
    logic o;
    command(en ? 8'b0011_0000 : 8'b0000_0000, o);
    deselect();
  endtask

  task automatic t_reset();
    check("R11 dout after reset", {15'd0, dout}, 16'd1);
    read_chk("R11 init word 5", 5, 1);
    read_chk("R3 address order word 33", 33, 1);
  endtask

  task automatic t_ignore();
    logic o;
    cs = 0;
    for (int i = 0; i < 9; i++) pulse(i != 1, o);
    check("R1 cs low edges ignored", {15'd0, dout}, 16'd1);
    cs = 1;
    for (int i = 0; i < 5; i++) pulse(1'b0, o);
    check("R2 zeros in idle ignored", {15'd0, o}, 16'd1);
    read_chk("R2 read after leading zeros", 3, 1);
  endtask

  task automatic t_protected();
    logic o;
    command(8'b01_000111, o); send_word(16'h1234); deselect();
    command(8'b11_001000, o); deselect();
    command(8'b00_100000, o); deselect();
    read_chk("R12 word 7 after blocked write", 7, 1);
    read_chk("R12 word 8 after blocked erase", 8, 1);
  endtask

  task automatic t_write();
    logic o;
    latch(1'b1);
    command(8'b01_000111, o); send_word(16'hA5C3);
    model[7] = 16'hA5C3;
    for (int i = 0; i < 9; i++) pulse(i != 2, o);
    check("R9 parked output stays high", {15'd0, o}, 16'd1);
    deselect();
    read_chk("R4 word write", 7, 1);
  endtask

  task automatic t_seq();
    read_chk("R6 sequential wrap", 62, 3);
  endtask

  task automatic t_erase();
    logic o;
    command(8'b11_000111, o); deselect();
    model[7] = 16'hFFFF;
    read_chk("R7 erase word", 7, 1);
  endtask

  task automatic t_all();
    logic o;
    command(8'b00_010000, o); send_word(16'h0F0F); deselect();
    for (int i = 0; i < 64; i++) model[i] = 16'h0F0F;
    read_chk("R8 write all low", 0, 1);
    read_chk("R8 write all high", 40, 1);
    command(8'b00_100000, o); deselect();
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    read_chk("R8 erase all", 10, 1);
    latch(1'b0);
    command(8'b01_000001, o); send_word(16'h0000); deselect();
    read_chk("R8 latch closed again", 1, 1);
  endtask

  task automatic t_abort();
    logic o; logic [15:0] w;
    command(8'b10_000010, o);
    for (int i = 0; i < 3; i++) pulse(1'b0, w[i]);
    cs = 0;
    repeat (2) @(negedge clk);
    check("R10 dout high after cs fall", {15'd0, dout}, 16'd1);
    deselect();
    read_chk("R10 fresh command after abort", 2, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = INIT ^ 16'(i);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ignore();
    t_protected();
    t_write();
    t_seq();
    t_erase();
    t_all();
    t_abort();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule